// File: doc/BRIEF.md
# Reader Frame FIFO with Direction-Dependent Watermark Interrupt

This block is the byte buffer between a host register port and the serial frame engine of a contactless reader front end. It holds up to twelve bytes in a circular store. While transmitting, the host fills it and the transmitter drains it. While receiving, the receiver fills it and the host drains it. The block reports the fill level as a count-minus-one code, with separate empty and full flags. It raises an interrupt request when the level suits the host: a low level while transmitting and a high level while receiving.

A frame may be longer than the buffer, so the transmit length is kept separately from the fill level. The length is a count of whole bytes plus a count of bits in one trailing partial byte. The block counts the bytes handed to the transmitter, marks the trailing byte as partial and pulses end-of-frame once the whole length has gone out. When the host writes a byte into an empty buffer in transmit mode, the block pulses a start signal to the transmitter.

Top module: `rfb_frame_fifo`

## Requirements
- R1: Bytes leave in the order they entered, and this order holds when the twelve-entry store wraps around. The head byte is visible on `tx_data_o` and `host_rdata_o`.
- R2: A one-cycle `clear_i` empties the store. After the clock edge, `empty_o`=1, `fill_code_o`=0, `ovf_o`=0 and `udf_o`=0.
- R3: With n bytes stored, `fill_code_o` reads n-1 for n>=1 and 0 for n=0. `empty_o` is 1 only when n=0, and `full_o` is 1 only when n=12.
- R4: A write while full is ignored and sets the sticky `ovf_o`. A read while empty is ignored and sets the sticky `udf_o`. Only `clear_i` clears these two flags.
- R5: An accepted write and an accepted read in the same cycle leave the fill level unchanged and keep the byte order.
- R6: With `dir_tx_i`=1 the host writes and the transmitter pops. With `dir_tx_i`=0 the receiver pushes and the host reads. The strobes of the side that does not own the direction have no effect.
- R7: The watermark condition is n<3 when `dir_tx_i`=1 and n>9 when `dir_tx_i`=0. `irq_o` rises one cycle after the condition holds. It stays high until a `stat_rd_i` cycle, drops at the following edge, and rises again one cycle later if the condition still holds.
- R8: An accepted host write into an empty store with `dir_tx_i`=1 gives a one-cycle `tx_start_o` pulse in the cycle after the write.
- R9: `len_load_i` loads a 12-bit byte count and a 4-bit bit count. With a bit count of 0, `eof_o` pulses for one cycle after the pop of the byte-count-th byte, and never before it.
- R10: With a nonzero bit count, after the byte-count pops `tx_partial_o`=1 and `tx_bits_o` equals the bit count. The pop of that partial byte gives the `eof_o` pulse.
- R11: Length counting is independent of the fill level, so a frame longer than twelve bytes ends only after its full length has been popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_tx_i | input | 1 | 1 = transmit direction, 0 = receive direction |
| clear_i | input | 1 | Buffer reset command |
| host_wr_i | input | 1 | Host write strobe (transmit) |
| host_wdata_i | input | 8 | Host write byte |
| host_rd_i | input | 1 | Host read strobe (receive) |
| host_rdata_o | output | 8 | Head byte for the host |
| rx_push_i | input | 1 | Receiver byte strobe (receive) |
| rx_data_i | input | 8 | Receiver byte |
| tx_pop_i | input | 1 | Transmitter takes the head byte |
| tx_data_o | output | 8 | Head byte for the transmitter |
| stat_rd_i | input | 1 | Status read, acknowledges the interrupt |
| fill_code_o | output | 4 | Stored bytes minus one (0 when empty) |
| empty_o | output | 1 | Store empty |
| full_o | output | 1 | Store full |
| ovf_o | output | 1 | Sticky write-while-full flag |
| udf_o | output | 1 | Sticky read-while-empty flag |
| irq_o | output | 1 | Watermark interrupt request |
| len_load_i | input | 1 | Load transmit length |
| len_bytes_i | input | 12 | Whole-byte count of the frame |
| len_bits_i | input | 4 | Valid bits in a trailing partial byte |
| tx_start_o | output | 1 | Transmission start pulse |
| tx_partial_o | output | 1 | Head byte is the trailing partial byte |
| tx_bits_o | output | 4 | Valid bits of the partial byte |
| eof_o | output | 1 | End-of-frame pulse |

## Verification
A corrupted pointer shows up as a wrong head byte at the first pop or host read after it, which the byte scoreboard catches at once. A miscounted fill level shows up in `fill_code_o`, in the flags and in a shifted interrupt edge, each within one cycle. A slip in the remaining-length counter only shows at the end of a frame, as an early, late or missing `eof_o` or partial-byte mark. For that reason, both frame tests check the cycle just before the final pop as well as the final pop itself, and one frame runs past the buffer depth with wrap-around.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
  localparam int unsigned RFB_DEPTH  = 12;
  localparam int unsigned RFB_WIDTH  = 8;
  localparam int unsigned RFB_LO     = 3;
  localparam int unsigned RFB_HI     = 9;
  localparam int unsigned RFB_LEN_W  = 12;
  localparam int unsigned RFB_BITS_W = 4;
endpackage

// File: rtl/rfb_store.sv
module rfb_store #(
  parameter int unsigned DEPTH = 12,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [CNT_W-1:0] count_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             wr_ok_o,
  output logic             rd_ok_o,
  output logic             ovf_o,
  output logic             udf_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] count_q;
  logic             ovf_q, udf_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign wr_ok_o = wr_i && !full_o && !clr_i;
  assign rd_ok_o = rd_i && !empty_o && !clr_i;
  assign rdata_o = mem_q[rptr_q];
  assign count_o = count_q;
  assign ovf_o   = ovf_q;
  assign udf_o   = udf_q;

  always_ff @(posedge clk_i) begin
    if (wr_ok_o) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
      ovf_q   <= 1'b0;
      udf_q   <= 1'b0;
    end else if (clr_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
      ovf_q   <= 1'b0;
      udf_q   <= 1'b0;
    end else begin
      if (wr_ok_o) wptr_q <= ptr_inc(wptr_q);
      if (rd_ok_o) rptr_q <= ptr_inc(rptr_q);
      if (wr_ok_o && !rd_ok_o)      count_q <= count_q + 1'b1;
      else if (rd_ok_o && !wr_ok_o) count_q <= count_q - 1'b1;
      if (wr_i && full_o)  ovf_q <= 1'b1;
      if (rd_i && empty_o) udf_q <= 1'b1;
    end
  end

  a_r3_count_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && full_o && !rd_i && !clr_i) |=> ($stable(count_q) && ovf_q));
  a_r4_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !clr_i) |=> ovf_q);
  a_r5_simul_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok_o && rd_ok_o) |=> $stable(count_q));
  a_r2_clear_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (empty_o && !ovf_q && !udf_q));
endmodule

// File: rtl/rfb_wmark.sv
module rfb_wmark #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned LO    = 3,
  parameter int unsigned HI    = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dir_tx_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             ack_i,
  output logic             irq_o
);
  logic cond, irq_q;

  assign cond  = dir_tx_i ? (count_i < CNT_W'(LO)) : (count_i > CNT_W'(HI));
  assign irq_o = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (ack_i) irq_q <= 1'b0;
    else            irq_q <= irq_q | cond;
  end

  a_r7_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !ack_i) |=> irq_q);
  a_r7_irq_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !irq_q);
endmodule

// File: rtl/rfb_txlen.sv
module rfb_txlen #(
  parameter int unsigned LEN_W  = 12,
  parameter int unsigned BITS_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LEN_W-1:0]  bytes_i,
  input  logic [BITS_W-1:0] bits_i,
  input  logic              pop_i,
  output logic              partial_o,
  output logic [BITS_W-1:0] bits_o,
  output logic              eof_o
);
  logic [LEN_W-1:0]  rem_q;
  logic [BITS_W-1:0] bits_q;
  logic              active_q, eof_q, last_pop;

  assign last_pop  = active_q && pop_i &&
                     ((rem_q == LEN_W'(1) && bits_q == '0) ||
                      (rem_q == '0 && bits_q != '0));
  assign partial_o = active_q && (rem_q == '0) && (bits_q != '0);
  assign bits_o    = partial_o ? bits_q : '0;
  assign eof_o     = eof_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q    <= '0;
      bits_q   <= '0;
      active_q <= 1'b0;
      eof_q    <= 1'b0;
    end else begin
      eof_q <= !load_i && last_pop;
      if (load_i) begin
        rem_q    <= bytes_i;
        bits_q   <= bits_i;
        active_q <= (bytes_i != '0) || (bits_i != '0);
      end else if (active_q && pop_i) begin
        if (rem_q != '0) rem_q <= rem_q - 1'b1;
        if (last_pop)    active_q <= 1'b0;
      end
    end
  end

  a_r9_eof_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_q |=> !eof_q);
  a_r10_partial_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (partial_o && !pop_i && !load_i) |=> (partial_o && $stable(bits_o)));
endmodule

// File: rtl/rfb_frame_fifo.sv
module rfb_frame_fifo
  import rfb_pkg::*;
#(
  parameter int unsigned DEPTH  = RFB_DEPTH,
  parameter int unsigned WIDTH  = RFB_WIDTH,
  parameter int unsigned LO     = RFB_LO,
  parameter int unsigned HI     = RFB_HI,
  parameter int unsigned LEN_W  = RFB_LEN_W,
  parameter int unsigned BITS_W = RFB_BITS_W,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned FC_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_tx_i,
  input  logic              clear_i,
  input  logic              host_wr_i,
  input  logic [WIDTH-1:0]  host_wdata_i,
  input  logic              host_rd_i,
  output logic [WIDTH-1:0]  host_rdata_o,
  input  logic              rx_push_i,
  input  logic [WIDTH-1:0]  rx_data_i,
  input  logic              tx_pop_i,
  output logic [WIDTH-1:0]  tx_data_o,
  input  logic              stat_rd_i,
  output logic [FC_W-1:0]   fill_code_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              ovf_o,
  output logic              udf_o,
  output logic              irq_o,
  input  logic              len_load_i,
  input  logic [LEN_W-1:0]  len_bytes_i,
  input  logic [BITS_W-1:0] len_bits_i,
  output logic              tx_start_o,
  output logic              tx_partial_o,
  output logic [BITS_W-1:0] tx_bits_o,
  output logic              eof_o
);
  logic             wr, rd, wr_ok, rd_ok;
  logic [WIDTH-1:0] wdata, head;
  logic [CNT_W-1:0] count;
  logic             start_q;

  // direction selects which side owns each end
  assign wr    = dir_tx_i ? host_wr_i : rx_push_i;
  assign wdata = dir_tx_i ? host_wdata_i : rx_data_i;
  assign rd    = dir_tx_i ? tx_pop_i : host_rd_i;

  rfb_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk_i, .rst_ni, .clr_i(clear_i), .wr_i(wr), .wdata_i(wdata), .rd_i(rd),
    .rdata_o(head), .count_o(count), .empty_o, .full_o,
    .wr_ok_o(wr_ok), .rd_ok_o(rd_ok), .ovf_o, .udf_o
  );

  rfb_wmark #(.CNT_W(CNT_W), .LO(LO), .HI(HI)) u_wmark (
    .clk_i, .rst_ni, .dir_tx_i, .count_i(count), .ack_i(stat_rd_i), .irq_o
  );

  rfb_txlen #(.LEN_W(LEN_W), .BITS_W(BITS_W)) u_txlen (
    .clk_i, .rst_ni, .load_i(len_load_i), .bytes_i(len_bytes_i),
    .bits_i(len_bits_i), .pop_i(rd_ok && dir_tx_i),
    .partial_o(tx_partial_o), .bits_o(tx_bits_o), .eof_o
  );

  assign host_rdata_o = head;
  assign tx_data_o    = head;
  assign fill_code_o  = (count == '0) ? '0 : FC_W'(count - 1'b1);
  assign tx_start_o   = start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= 1'b0;
    else         start_q <= dir_tx_i && wr_ok && (count == '0);
  end

  a_r8_start_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> !empty_o);
  a_r6_rx_no_host_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_tx_i && !rx_push_i && !host_rd_i && !clear_i) |=> $stable(count));
endmodule

// File: tb/rfb_frame_fifo_tb_top.sv
module rfb_frame_fifo_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        dir_tx = 1'b0, clear = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0, rx_push = 1'b0, tx_pop = 1'b0;
  logic [7:0]  host_wdata = '0, rx_data = '0, host_rdata, tx_data;
  logic        stat_rd = 1'b0, len_load = 1'b0;
  logic [11:0] len_bytes = '0;
  logic [3:0]  len_bits = '0, fill_code, tx_bits;
  logic        empty, full, ovf, udf, irq, tx_start, tx_partial, eof;

  int checks = 0, errors = 0, cycles = 0, mdl_cnt = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  rfb_frame_fifo dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dir_tx_i(dir_tx), .clear_i(clear),
    .host_wr_i(host_wr), .host_wdata_i(host_wdata), .host_rd_i(host_rd),
    .host_rdata_o(host_rdata), .rx_push_i(rx_push), .rx_data_i(rx_data),
    .tx_pop_i(tx_pop), .tx_data_o(tx_data), .stat_rd_i(stat_rd),
    .fill_code_o(fill_code), .empty_o(empty), .full_o(full), .ovf_o(ovf),
    .udf_o(udf), .irq_o(irq), .len_load_i(len_load), .len_bytes_i(len_bytes),
    .len_bits_i(len_bits), .tx_start_o(tx_start), .tx_partial_o(tx_partial),
    .tx_bits_o(tx_bits), .eof_o(eof)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  // driver: one host write (transmit side)
  task automatic hwrite(input logic [7:0] d);
    host_wr = 1'b1; host_wdata = d;
    if (mdl_cnt < 12) begin exp_q.push_back(d); mdl_cnt++; end
    step(); host_wr = 1'b0;
  endtask

  task automatic rpush(input logic [7:0] d);
    rx_push = 1'b1; rx_data = d;
    if (mdl_cnt < 12) begin exp_q.push_back(d); mdl_cnt++; end
    step(); rx_push = 1'b0;
  endtask

  task automatic tpop();
    tx_pop = 1'b1; step(); tx_pop = 1'b0;
    if (mdl_cnt > 0) mdl_cnt--;
  endtask

  task automatic hread();
    host_rd = 1'b1; step(); host_rd = 1'b0;
    if (mdl_cnt > 0) mdl_cnt--;
  endtask

  task automatic do_clear();
    clear = 1'b1; step(); clear = 1'b0;
    exp_q.delete(); mdl_cnt = 0;
  endtask

  task automatic load_len(input int b, input int bits);
    len_load = 1'b1; len_bytes = 12'(b); len_bits = 4'(bits);
    step(); len_load = 1'b0;
  endtask

  task automatic ack();
    stat_rd = 1'b1; step(); stat_rd = 1'b0;
  endtask

  // monitor: scoreboard compare of the head byte on each accepted read (R1)
  always @(negedge clk) begin
    if (rst_n && !clear && !empty) begin
      if (dir_tx && tx_pop) begin
        logic [7:0] e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
        chk(tx_data === e, "R1 tx byte order", tx_data, e);
      end else if (!dir_tx && host_rd) begin
        logic [7:0] e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
        chk(host_rdata === e, "R1 rx byte order", host_rdata, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #35 rst_n = 1'b1;
    step();
    // reset state
    chk(empty && !full && fill_code == 0, "R3 reset empty", fill_code, 0);
    chk(!ovf && !udf && !irq, "R7 reset flags", {ovf, udf, irq}, 0);

    // transmit direction: low level raises irq one cycle later
    dir_tx = 1'b1; step();
    chk(irq == 1'b1, "R7 tx low-water irq", irq, 1);
    hwrite(8'h10);
    chk(tx_start == 1'b1, "R8 start pulse", tx_start, 1);
    chk(fill_code == 0 && !empty, "R3 one byte code", fill_code, 0);
    hwrite(8'h11);
    chk(tx_start == 1'b0, "R8 start single cycle", tx_start, 0);
    for (int i = 2; i < 8; i++) hwrite(8'h10 + 8'(i));
    chk(fill_code == 7, "R3 eight bytes code", fill_code, 7);
    for (int i = 8; i < 12; i++) hwrite(8'h10 + 8'(i));
    chk(full && fill_code == 11, "R3 full code", fill_code, 11);
    hwrite(8'hEE);
    chk(ovf && fill_code == 11, "R4 write when full ignored", {ovf, fill_code}, 16 + 11);
    // R6: receiver push ignored in transmit direction
    tpop();
    rx_push = 1'b1; rx_data = 8'h55; step(); rx_push = 1'b0;
    chk(fill_code == 10, "R6 rx push ignored in tx", fill_code, 10);
    // R5: simultaneous write and pop
    host_wr = 1'b1; host_wdata = 8'hA5; tx_pop = 1'b1;
    exp_q.push_back(8'hA5);
    step(); host_wr = 1'b0; tx_pop = 1'b0;
    chk(fill_code == 10, "R5 simultaneous level", fill_code, 10);
    while (mdl_cnt > 0) tpop();
    chk(empty, "R1 drained", empty, 1);
    tpop();
    chk(udf == 1'b1, "R4 pop when empty sets udf", udf, 1);
    chk(ovf == 1'b1, "R4 ovf still sticky", ovf, 1);
    do_clear();
    chk(empty && !ovf && !udf && fill_code == 0, "R2 clear", {ovf, udf}, 0);

    // frame of 5 whole bytes
    load_len(5, 0);
    for (int i = 0; i < 5; i++) hwrite(8'h30 + 8'(i));
    for (int i = 0; i < 4; i++) tpop();
    chk(eof == 1'b0, "R9 no early eof", eof, 0);
    tpop();
    chk(eof == 1'b1, "R9 eof after last byte", eof, 1);
    step();
    chk(eof == 1'b0, "R9 eof one cycle", eof, 0);

    // frame of 14 bytes plus 3 bits, longer than the store
    load_len(14, 3);
    for (int i = 0; i < 12; i++) hwrite(8'h40 + 8'(i));
    for (int i = 0; i < 10; i++) tpop();
    for (int i = 12; i < 16; i++) hwrite(8'h40 + 8'(i));
    for (int i = 0; i < 3; i++) tpop();
    chk(eof == 1'b0 && tx_partial == 1'b0, "R11 no eof at 13 bytes", eof, 0);
    tpop();
    chk(eof == 1'b0, "R11 no eof at byte count", eof, 0);
    chk(tx_partial == 1'b1 && tx_bits == 3, "R10 partial byte mark", tx_bits, 3);
    tpop();
    chk(eof == 1'b1, "R10 eof after partial byte", eof, 1);
    chk(tx_partial == 1'b0, "R10 partial cleared", tx_partial, 0);
    do_clear();

    // receive direction
    dir_tx = 1'b0; ack(); step();
    chk(irq == 1'b0, "R7 rx idle no irq", irq, 0);
    for (int i = 0; i < 10; i++) rpush(8'h60 + 8'(i));
    chk(irq == 1'b0, "R7 irq not yet", irq, 0);
    step();
    chk(irq == 1'b1, "R7 rx high-water irq", irq, 1);
    host_wr = 1'b1; host_wdata = 8'h99; step(); host_wr = 1'b0;
    tx_pop = 1'b1; step(); tx_pop = 1'b0;
    chk(fill_code == 9, "R6 host write and tx pop ignored in rx", fill_code, 9);
    hread(); hread();
    chk(irq == 1'b1, "R7 irq held", irq, 1);
    ack();
    chk(irq == 1'b0, "R7 irq acked", irq, 0);
    step();
    chk(irq == 1'b0, "R7 irq stays low", irq, 0);
    for (int i = 0; i < 3; i++) rpush(8'h70 + 8'(i));
    ack(); step();
    chk(irq == 1'b1, "R7 irq re-raised after ack", irq, 1);
    while (mdl_cnt > 0) hread();
    chk(empty, "R1 rx drained", empty, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule